// File: doc/BRIEF.md
# Operating-Point Transition Sequencer

This block moves a processor core from its present voltage and frequency operating point to a requested one. It holds a fixed table of operating points. Each point carries a frequency code, a clock source id, a mux select and divider, a minimum bus rate code, a supply voltage in millivolts and, for points on the reprogrammable PLL, the PLL's L, M and N values and a pre-divide flag. A request names the target frequency and a reason. The block finds the matching point and sends an ordered series of commands through one valid/ack command channel. A regulator, a bus-clock manager, the source gates, the PLL and the clock mux answer on that channel, each with a pass or fail response.

Moves that raise the voltage or the bus rate do so before the core clock is switched. Moves that lower them do so afterwards. If the core already runs from the reprogrammable PLL and must stay on it at a new rate, the core is first parked on a backup point while the PLL is rewritten. Two special reasons cut the sequence short: idle-wait stops right after the switch, and power-collapse stops before the voltage is lowered. Each request ends with a one-cycle `done` pulse that carries an error flag and a warning flag.

Top module: `opp_seq`

## Requirements
- R1: After reset `req_ready` is 1, `cmd_valid` and `done` are 0, and `cur_freq` is 240, the frequency of entry 3. The default table lists index: freq/src/sel/div/bus/mV. 0: 20/6/0/0/30/850; 1: 120/3/5/5/60/900; 2: 190/7/1/0/60/900; 3: 240/3/5/2/60/900; 4: 760/1/2/0/150/1050; 5: 800/2/3/0/255/1100 with PLL 42,0,1,0; 6: 1000/2/3/0/255/1200 with PLL 53,1,3,0; 7: 1400/2/3/0/255/1250 with PLL 73,0,1,1. Entry 4 is the backup point.
- R2: A requested frequency that matches no entry ends with `done`=1 and `err`=1. No command is issued and `cur_freq` is unchanged.
- R3: A request for the frequency in `cur_freq` ends with `done`=1, `err`=0 and no command.
- R4: If the target voltage is higher, the first command is a voltage command (kind 0) whose data[7:0] has bits 7:6 set, bit 5 set, and bits 4:0 equal to mV/25 − 30. After it passes, no command is issued for at least SETTLE_NS/CLK_PS cycles (7750 by default).
- R5: If the target bus rate code is higher, a bus command (kind 1, data[7:0] = rate) is issued before the switch. A fail response to a voltage or bus raise ends the request with `err`=1 and no further command. `cur_freq` is then unchanged.
- R6: When both the start and the target point use source 2, the order is: source-on (kind 2) of the backup source, mux (kind 5) to the backup point, source-off (kind 3) of source 2, PLL write (kind 4, data = {pre[16], N[15:12], M[11:8], L[7:0]}), source-on of 2, then the mux to the target. A PLL write is issued whenever the target uses source 2.
- R7: A source id with bit 2 set is fixed. It never appears in a source-on or source-off command. Source-on and source-off carry the id in data[2:0]. The target source is turned on before the switch when it differs from the start source.
- R8: The switch is a mux command with data[6:4] = select and data[3:0] = divider, and `cur_freq` takes the target value when it passes. After it, the backup source is turned off if the backup was used. The start source is turned off if it differs from the target source and is gateable.
- R9: With reason 1 (idle-wait) the sequence ends after the switch, including any backup release. With reason 2 (power-collapse) it ends after the bus decrease and issues no voltage decrease. Reasons 0 and 3 run the full sequence.
- R10: A fail response to a bus or voltage decrease, or to any command after the raises, sets `warn` with `done` and leaves `err` at 0.
- R11: `req_ready` drops in the cycle after a request is taken and returns only with `done`.
- R12: A command keeps `cmd_valid`, `cmd_kind` and `cmd_data` steady until `cmd_ack`, and only one command is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_freq | input | 16 | Requested frequency code |
| req_reason | input | 2 | 0 normal, 1 idle-wait, 2 power-collapse |
| cmd_valid | output | 1 | Command present |
| cmd_kind | output | 3 | 0 voltage, 1 bus rate, 2 source on, 3 source off, 4 PLL write, 5 mux |
| cmd_data | output | 24 | Command payload |
| cmd_ack | input | 1 | Command consumed this cycle |
| cmd_fail | input | 1 | Response with `cmd_ack`: the command failed |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Request rejected or aborted, valid with `done` |
| warn | output | 1 | A late command failed, valid with `done` |
| cur_freq | output | 16 | Frequency of the point in use |

## Verification
The hardest case to reach is the park-on-backup path. It needs a start point already on the reprogrammable PLL, so the bench first walks the core onto that PLL with earlier requests and only then asks for another rate on it. Fail responses are planned per command in the scoreboard entries. This lets a raise fail partway through one request and both decreases fail in another. One request stretches every acknowledgement by several cycles to show that commands are held steady.

// File: rtl/opp_pkg.sv
package opp_pkg;
  localparam int FREQ_W = 16;
  localparam int DATA_W = 24;

  typedef enum logic [2:0] {
    CMD_VOLT = 3'd0, CMD_BUS = 3'd1, CMD_SRC_ON = 3'd2,
    CMD_SRC_OFF = 3'd3, CMD_PLL = 3'd4, CMD_MUX = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    RSN_NORMAL = 2'd0, RSN_IDLE = 2'd1, RSN_PC = 2'd2, RSN_RSVD = 2'd3
  } rsn_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LOOK, ST_VUP, ST_SETTLE, ST_BUP, ST_BKON, ST_BKMUX, ST_POFF,
    ST_PCFG, ST_TON, ST_SW, ST_BKOFF, ST_OOFF, ST_BDN, ST_VDN, ST_FIN
  } step_e;

  typedef struct packed {
    logic [FREQ_W-1:0] freq;
    logic [2:0]        src;   // bit 2 set: fixed source, never gated
    logic [2:0]        sel;
    logic [3:0]        div;
    logic [7:0]        bus;
    logic [10:0]       mv;
    logic [7:0]        pl;
    logic [3:0]        pm;
    logic [3:0]        pn;
    logic              pre;
  } opp_t;

  function automatic opp_t mk(int f, int s, int se, int dv, int b, int m,
                              int l, int mm, int n, int p);
    opp_t e;
    e.freq = FREQ_W'(f);
    e.src  = 3'(s);
    e.sel  = 3'(se);
    e.div  = 4'(dv);
    e.bus  = 8'(b);
    e.mv   = 11'(m);
    e.pl   = 8'(l);
    e.pm   = 4'(mm);
    e.pn   = 4'(n);
    e.pre  = 1'(p);
    return e;
  endfunction

  function automatic opp_t opp_entry(int i);
    case (i)
      0: return mk(20,   6, 0, 0, 30,  850,  0, 0, 0, 0);
      1: return mk(120,  3, 5, 5, 60,  900,  0, 0, 0, 0);
      2: return mk(190,  7, 1, 0, 60,  900,  0, 0, 0, 0);
      3: return mk(240,  3, 5, 2, 60,  900,  0, 0, 0, 0);
      4: return mk(760,  1, 2, 0, 150, 1050, 0, 0, 0, 0);
      5: return mk(800,  2, 3, 0, 255, 1100, 42, 0, 1, 0);
      6: return mk(1000, 2, 3, 0, 255, 1200, 53, 1, 3, 0);
      7: return mk(1400, 2, 3, 0, 255, 1250, 73, 0, 1, 1);
      default: return '0;
    endcase
  endfunction

  function automatic logic [7:0] volt_code(logic [10:0] mv);
    int st;
    st = int'(mv) / 25 - 30;
    return {3'b111, st[4:0]};
  endfunction

  function automatic logic gateable(logic [2:0] s);
    return !s[2];
  endfunction

  function automatic step_e next_step(step_e s, rsn_e r);
    case (s)
      ST_VUP:   return ST_SETTLE;
      ST_SETTLE: return ST_BUP;
      ST_BUP:   return ST_BKON;
      ST_BKON:  return ST_BKMUX;
      ST_BKMUX: return ST_POFF;
      ST_POFF:  return ST_PCFG;
      ST_PCFG:  return ST_TON;
      ST_TON:   return ST_SW;
      ST_SW:    return ST_BKOFF;
      ST_BKOFF: return (r == RSN_IDLE) ? ST_FIN : ST_OOFF;
      ST_OOFF:  return ST_BDN;
      ST_BDN:   return (r == RSN_PC) ? ST_FIN : ST_VDN;
      ST_VDN:   return ST_FIN;
      default:  return ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/opp_table.sv
module opp_table import opp_pkg::*; #(
  parameter int N_OPP = 8,
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FREQ_W-1:0] key,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  input  logic [IDX_W-1:0]  rd0_idx,
  output opp_t              rd0,
  input  logic [IDX_W-1:0]  rd1_idx,
  output opp_t              rd1
);
  logic [N_OPP-1:0] match;

  for (genvar g = 0; g < N_OPP; g++) begin : g_cmp
    localparam opp_t ENT = opp_entry(g);
    assign match[g] = (ENT.freq == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N_OPP - 1; i >= 0; i--)
      if (match[i]) hit_idx = IDX_W'(i);
  end

  assign hit = |match;
  assign rd0 = opp_entry(int'(rd0_idx));
  assign rd1 = opp_entry(int'(rd1_idx));

  AST_LOOKUP_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match)); // R2
endmodule

// File: rtl/opp_settle_timer.sv
module opp_settle_timer #(
  parameter int CYC = 7750
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (go)        cnt <= CW'(CYC);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  AST_SETTLE_LOAD: assert property (@(posedge clk) disable iff (rst)
    go |=> !done); // R4
  AST_SETTLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!go && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R4
endmodule

// File: rtl/opp_cmd_fmt.sv
module opp_cmd_fmt import opp_pkg::*; #(
  parameter logic [2:0] PLL_SRC = 3'd2
) (
  input  step_e             step,
  input  opp_t              cur,
  input  opp_t              tgt,
  input  opp_t              bak,
  output logic              need,
  output cmd_e              kind,
  output logic [DATA_W-1:0] data
);
  logic both;
  assign both = (cur.src == PLL_SRC) && (tgt.src == PLL_SRC);

  always_comb begin
    need = 1'b0;
    kind = CMD_VOLT;
    data = '0;
    case (step)
      ST_VUP:   begin need = tgt.mv > cur.mv;   data[7:0] = volt_code(tgt.mv); end
      ST_BUP:   begin need = tgt.bus > cur.bus; kind = CMD_BUS; data[7:0] = tgt.bus; end
      ST_BKON:  begin need = both && gateable(bak.src); kind = CMD_SRC_ON; data[2:0] = bak.src; end
      ST_BKMUX: begin need = both; kind = CMD_MUX; data[6:0] = {bak.sel, bak.div}; end
      ST_POFF:  begin need = both; kind = CMD_SRC_OFF; data[2:0] = PLL_SRC; end
      ST_PCFG:  begin
        need = tgt.src == PLL_SRC;
        kind = CMD_PLL;
        data[16:0] = {tgt.pre, tgt.pn, tgt.pm, tgt.pl};
      end
      ST_TON:   begin
        need = ((cur.src != tgt.src) && gateable(tgt.src)) || both;
        kind = CMD_SRC_ON; data[2:0] = tgt.src;
      end
      ST_SW:    begin need = 1'b1; kind = CMD_MUX; data[6:0] = {tgt.sel, tgt.div}; end
      ST_BKOFF: begin need = both && gateable(bak.src); kind = CMD_SRC_OFF; data[2:0] = bak.src; end
      ST_OOFF:  begin
        need = (cur.src != tgt.src) && gateable(cur.src);
        kind = CMD_SRC_OFF; data[2:0] = cur.src;
      end
      ST_BDN:   begin need = tgt.bus < cur.bus; kind = CMD_BUS; data[7:0] = tgt.bus; end
      ST_VDN:   begin need = tgt.mv < cur.mv;   data[7:0] = volt_code(tgt.mv); end
      default:  need = 1'b0;
    endcase
  end
endmodule

// File: rtl/opp_seq.sv
module opp_seq import opp_pkg::*; #(
  parameter int N_OPP     = 8,
  parameter int RESET_IDX = 3,
  parameter int BAK_IDX   = 4,
  parameter int PLL_SRC   = 2,
  parameter int CLK_PS    = 8000,
  parameter int SETTLE_NS = 62000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FREQ_W-1:0] req_freq,
  input  logic [1:0]        req_reason,
  output logic              cmd_valid,
  output logic [2:0]        cmd_kind,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_ack,
  input  logic              cmd_fail,
  output logic              done,
  output logic              err,
  output logic              warn,
  output logic [FREQ_W-1:0] cur_freq
);
  localparam int   SETTLE_CYC = (SETTLE_NS * 1000) / CLK_PS;
  localparam int   IDX_W      = (N_OPP > 1) ? $clog2(N_OPP) : 1;
  localparam opp_t BAK_E      = opp_entry(BAK_IDX);
  localparam opp_t RST_E      = opp_entry(RESET_IDX);

  step_e             step;
  rsn_e              rsn_q;
  logic [FREQ_W-1:0] key_q;
  logic [IDX_W-1:0]  cur_idx, start_idx, tgt_idx, hit_idx;
  logic              hit, warn_q, need, tmr_go, tmr_done;
  opp_t              start_e, tgt_e;
  cmd_e              fmt_kind;
  logic [DATA_W-1:0] fmt_data;

  opp_table #(.N_OPP(N_OPP), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst), .key(key_q), .hit(hit), .hit_idx(hit_idx),
    .rd0_idx(start_idx), .rd0(start_e), .rd1_idx(tgt_idx), .rd1(tgt_e)
  );

  opp_cmd_fmt #(.PLL_SRC(3'(PLL_SRC))) u_fmt (
    .step(step), .cur(start_e), .tgt(tgt_e), .bak(BAK_E),
    .need(need), .kind(fmt_kind), .data(fmt_data)
  );

  assign tmr_go = (step == ST_VUP) && cmd_valid && cmd_ack && !cmd_fail;

  opp_settle_timer #(.CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst(rst), .go(tmr_go), .done(tmr_done)
  );

  assign req_ready = (step == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      step      <= ST_IDLE;
      rsn_q     <= RSN_NORMAL;
      key_q     <= '0;
      cur_idx   <= IDX_W'(RESET_IDX);
      start_idx <= '0;
      tgt_idx   <= '0;
      cur_freq  <= RST_E.freq;
      cmd_valid <= 1'b0;
      cmd_kind  <= '0;
      cmd_data  <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      warn      <= 1'b0;
      warn_q    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (step)
        ST_IDLE: if (req_valid) begin
          key_q <= req_freq;
          rsn_q <= rsn_e'(req_reason);
          step  <= ST_LOOK;
        end
        ST_LOOK: begin
          if (key_q == cur_freq || !hit) begin
            done <= 1'b1;
            err  <= (key_q != cur_freq);
            warn <= 1'b0;
            step <= ST_IDLE;
          end else begin
            tgt_idx   <= hit_idx;
            start_idx <= cur_idx;
            warn_q    <= 1'b0;
            step      <= ST_VUP;
          end
        end
        ST_SETTLE: if (tmr_done) step <= ST_BUP;
        ST_FIN: begin
          done <= 1'b1;
          err  <= 1'b0;
          warn <= warn_q;
          step <= ST_IDLE;
        end
        default: begin
          if (!cmd_valid) begin
            if (need) begin
              cmd_valid <= 1'b1;
              cmd_kind  <= fmt_kind;
              cmd_data  <= fmt_data;
            end else begin
              step <= (step == ST_VUP) ? ST_BUP : next_step(step, rsn_q);
            end
          end else if (cmd_ack) begin
            cmd_valid <= 1'b0;
            if (cmd_fail && (step == ST_VUP || step == ST_BUP)) begin
              done <= 1'b1;
              err  <= 1'b1;
              warn <= 1'b0;
              step <= ST_IDLE;
            end else begin
              if (cmd_fail) warn_q <= 1'b1;
              if (step == ST_SW) begin
                cur_idx  <= tgt_idx;
                cur_freq <= tgt_e.freq;
              end
              step <= next_step(step, rsn_q);
            end
          end
        end
      endcase
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_kind) && $stable(cmd_data))); // R12
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_FIXED_NOT_GATED: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_kind == CMD_SRC_ON || cmd_kind == CMD_SRC_OFF)) |-> !cmd_data[2]); // R7
  AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (step == ST_SETTLE) |-> !cmd_valid); // R4
  AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !cmd_valid); // R3
  AST_ERR_NOT_WARN: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> !warn); // R10
  AST_ABORT_KEEPS_FREQ: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> $stable(cur_freq)); // R5
endmodule

// File: tb/opp_seq_tb.sv
module opp_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_freq = '0;
  logic [1:0]  req_reason = '0;
  logic        cmd_valid;
  logic [2:0]  cmd_kind;
  logic [23:0] cmd_data;
  logic        cmd_ack = 1'b0;
  logic        cmd_fail = 1'b0;
  logic        done, err, warn;
  logic [15:0] cur_freq;

  always #4 clk = ~clk;

  opp_seq u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_freq(req_freq), .req_reason(req_reason), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_data(cmd_data), .cmd_ack(cmd_ack),
    .cmd_fail(cmd_fail), .done(done), .err(err), .warn(warn),
    .cur_freq(cur_freq)
  );

  typedef struct {
    bit [2:0]  k;
    bit [23:0] d;
    bit        fail;
    bit        up;
  } exp_t;

  exp_t  exp_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 0;
  int    cyc = 0;
  int    last_vup = -1;
  int    ack_delay = 0;
  string cur_tag = "R1";
  bit        seen = 0;
  int        wl = 0;
  bit [2:0]  fk;
  bit [23:0] fd;
  exp_t      it;

  localparam int SETTLE = 62000 / 8;

  task automatic chk(bit ok, string rq, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  function automatic bit [23:0] vc(int mv);
    return 24'(8'hE0 | 8'(mv / 25 - 30));
  endfunction

  function automatic bit [23:0] mx(int sel, int dv);
    return 24'((sel << 4) | dv);
  endfunction

  function automatic bit [23:0] pc(int l, int m, int n, int p);
    return 24'((p << 16) | (n << 12) | (m << 8) | l);
  endfunction

  task automatic push(int k, bit [23:0] d, bit fail = 0, bit up = 0);
    exp_t e;
    e.k = 3'(k); e.d = d; e.fail = fail; e.up = up;
    exp_q.push_back(e);
  endtask

  // responder and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cmd_ack) begin
        cmd_ack = 1'b0; cmd_fail = 1'b0; seen = 0;
      end else if (cmd_valid) begin
        if (!seen) begin
          seen = 1; fk = cmd_kind; fd = cmd_data; wl = ack_delay;
          if (last_vup >= 0) begin
            chk(cyc - last_vup >= SETTLE, "R4", "settle gap", cyc - last_vup, SETTLE);
            last_vup = -1;
          end
        end else begin
          chk(cmd_kind == fk && cmd_data == fd, "R12", "held command", {cmd_kind, cmd_data}, {fk, fd});
        end
        if (wl > 0) wl--;
        else begin
          if (exp_q.size() == 0)
            chk(0, cur_tag, "unexpected command", {cmd_kind, cmd_data}, 0);
          else begin
            it = exp_q.pop_front();
            chk(cmd_kind == it.k && cmd_data == it.d, cur_tag, "command",
                {cmd_kind, cmd_data}, {it.k, it.d});
            cmd_fail = it.fail;
            if (it.up) last_vup = cyc;
          end
          cmd_ack = 1'b1;
        end
      end
    end
  end

  task automatic do_req(int f, int rsn, bit e_err, bit e_warn, int e_cur, string tag);
    int w = 0;
    cur_tag = tag;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_freq = 16'(f); req_reason = 2'(rsn);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11", "ready after take", req_ready, 0);
    while (!done && w < 60000) begin
      @(negedge clk); w++;
      if (!done) chk(req_ready == 1'b0, "R11", "ready while busy", req_ready, 0);
    end
    chk(done == 1'b1, tag, "done seen", done, 1);
    chk(err == e_err, tag, "err flag", err, e_err);
    chk(warn == e_warn, tag, "warn flag", warn, e_warn);
    chk(exp_q.size() == 0, tag, "commands missing", exp_q.size(), 0);
    chk(cur_freq == 16'(e_cur), tag, "cur_freq", cur_freq, e_cur);
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready after done", req_ready, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
    chk(cmd_valid == 1'b0, "R1", "reset cmd_valid", cmd_valid, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    chk(cur_freq == 16'd240, "R1", "reset cur_freq", cur_freq, 240);

    // R2: unknown frequency
    do_req(555, 0, 1, 0, 240, "R2");
    // R3: same frequency
    do_req(240, 0, 0, 0, 240, "R3");

    // R4 R5 R7 R8: 240 -> 760, slow acks for R12
    ack_delay = 3;
    push(0, vc(1050), 0, 1); push(1, 24'd150); push(2, 24'd1);
    push(5, mx(2, 0)); push(3, 24'd3);
    do_req(760, 0, 0, 0, 760, "R4");
    ack_delay = 0;

    // R6 (target on PLL only): 760 -> 800
    push(0, vc(1100), 0, 1); push(1, 24'd255); push(4, pc(42, 0, 1, 0));
    push(2, 24'd2); push(5, mx(3, 0)); push(3, 24'd1);
    do_req(800, 0, 0, 0, 800, "R6");

    // R6 park on backup: 800 -> 1400
    push(0, vc(1250), 0, 1); push(2, 24'd1); push(5, mx(2, 0)); push(3, 24'd2);
    push(4, pc(73, 0, 1, 1)); push(2, 24'd2); push(5, mx(3, 0)); push(3, 24'd1);
    do_req(1400, 0, 0, 0, 1400, "R8");

    // R9 power-collapse: 1400 -> 190, no voltage decrease; fixed target R7
    push(5, mx(1, 0)); push(3, 24'd2); push(1, 24'd60);
    do_req(190, 2, 0, 0, 190, "R9");

    // R7: fixed start source is not turned off: 190 -> 1000
    push(0, vc(1200), 0, 1); push(1, 24'd255); push(4, pc(53, 1, 3, 0));
    push(2, 24'd2); push(5, mx(3, 0));
    do_req(1000, 0, 0, 0, 1000, "R7");

    // R9 idle-wait: 1000 -> 120, ends after switch
    push(2, 24'd3); push(5, mx(5, 5));
    do_req(120, 1, 0, 0, 120, "R9");

    // R5 bus raise fails: 120 -> 760
    push(0, vc(1050), 0, 1); push(1, 24'd150, 1);
    do_req(760, 0, 1, 0, 120, "R5");
    last_vup = -1;

    // normal 120 -> 760
    push(0, vc(1050), 0, 1); push(1, 24'd150); push(2, 24'd1);
    push(5, mx(2, 0)); push(3, 24'd3);
    do_req(760, 0, 0, 0, 760, "R8");

    // R10: both decreases fail: 760 -> 20
    push(5, mx(0, 0)); push(3, 24'd1); push(1, 24'd30, 1); push(0, vc(850), 1);
    do_req(20, 0, 0, 1, 20, "R10");

    // R5 voltage raise fails: 20 -> 760
    push(0, vc(1050), 1);
    do_req(760, 0, 1, 0, 20, "R5");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 180000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule